// File: doc/BRIEF.md
# Gradient Correlation Window Accumulator

This block is the first stage of a texture-difference measure in a streaming video pipeline. It takes four signed gradients per pixel: horizontal and vertical for the live frame, and horizontal and vertical for the background model. From these it forms three correlation terms per pixel. The first is a mixed term that pairs live with background. The other two are the energy of the live gradients and the energy of the background gradients. Each term is then summed over a square neighbourhood. A later stage, outside this block, turns the three neighbourhood sums into a texture score.

Pixels arrive in raster order, one per clock at most. A start-of-frame flag marks the first pixel of a frame and a start-of-line flag marks the first pixel of every line. There is no ready signal and the block never stalls its source. The valid input may drop for any number of cycles, for example during blanking; data and flags seen while it is low are ignored.

Each accepted pixel produces exactly one result, a fixed number of cycles later. That result carries the pixel's own flags. The window of a result has the pixel as its newest sample, so it spans the pixel's line and the four lines above it, and the pixel's column and the four columns to its left. It is therefore the window centred two lines up and two columns left of the pixel that carries the flags. Window positions before the first line or the first column of the frame contribute zero. Four line stores, each as deep as the longest line, feed a register array that holds the window. Each of the three channels is then reduced by its own adder tree, with registers between the levels.

Top module: `grad_corr_window_sum`

## Requirements
- R1: For each pixel the block forms three terms from live gradients (lx, ly) and background gradients (kx, ky): mix = lx*kx + ly*ky, live energy = lx*lx + ly*ly, background energy = kx*kx + ky*ky. Each term is exact at 2*GRAD_W+1 bits, and each window sum satisfies mix^2 <= live energy * background energy.
- R2: The result for the pixel at line r, column c of a frame is the sum of each term over lines r-4..r and columns c-4..c. Results appear in the order the pixels were accepted, one per accepted pixel.
- R3: A window position with a negative line or column index contributes zero. The first pixel of a frame therefore yields exactly its own three terms.
- R4: Every result leaves exactly 7 clock cycles after its pixel is sampled (two stages of term and window registers, then five levels of adder tree). out_sof and out_sol equal the start-of-frame and start-of-line flags of that pixel.
- R5: While in_valid is low, the data and flag inputs have no effect. A frame sent with idle cycles between pixels and between lines gives the same results as the same frame sent without gaps.
- R6: A start-of-frame flag restarts line counting. Lines held from the previous frame never enter the windows of the new frame's first four lines.
- R7: The sums are SUM_W = 2*GRAD_W+1+ceil(log2(25)) = 28 bits, signed, two's complement. Full-scale inputs (every gradient at -1024, or live at -1024 against background at +1023) produce exact sums with no wrap.
- R8: While reset is asserted, and until the first accepted pixel has passed through the pipeline, out_valid, out_sof and out_sol are 0.
- R9: out_sof and out_sol are 0 in every cycle in which out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Pixel present this cycle |
| in_sof | input | 1 | First pixel of a frame (also counts as a line start) |
| in_sol | input | 1 | First pixel of a line |
| live_gx | input | GRAD_W | Live-frame horizontal gradient, signed |
| live_gy | input | GRAD_W | Live-frame vertical gradient, signed |
| bkg_gx | input | GRAD_W | Background horizontal gradient, signed |
| bkg_gy | input | GRAD_W | Background vertical gradient, signed |
| out_valid | output | 1 | Result present this cycle |
| out_sof | output | 1 | Result belongs to the first pixel of a frame |
| out_sol | output | 1 | Result belongs to the first pixel of a line |
| out_mix | output | SUM_W | Window sum of the mixed term, signed |
| out_live_e | output | SUM_W | Window sum of the live energy, signed |
| out_bkg_e | output | SUM_W | Window sum of the background energy, signed |

## Verification
The bench goes after the frame edges first. It uses a frame of all-one gradients, whose sums count the in-frame window positions. A design that failed to zero positions left of column four or above line four would carry old line-store data or stale columns into these sums. A frame sent right after a full-scale frame exposes any failure to restart line counting at start of frame: the full-scale values would leak into the new top rows. The bench repeats a random frame with idle cycles and junk data in the gaps. A design that advanced its column or window on an invalid cycle would misalign every later window and its latency. Extreme gradients and a lone non-zero pixel check term widths and signs; a product or sum one bit too narrow would wrap to the wrong sign.

// File: rtl/gcw_pkg.sv
`timescale 1ns/1ps
package gcw_pkg;

  localparam int NUM_CH = 3;

  typedef enum int {
    CH_MIX    = 0,
    CH_LIVE_E = 1,
    CH_BKG_E  = 2
  } corr_ch_e;

  function automatic int tree_levels(input int n);
    int k;
    int d;
    k = n;
    d = 0;
    while (k > 1) begin
      k = (k + 1) / 2;
      d = d + 1;
    end
    return d;
  endfunction

  function automatic int level_width(input int n, input int lvl);
    int k;
    k = n;
    for (int i = 0; i < lvl; i++) k = (k + 1) / 2;
    return k;
  endfunction

endpackage

// File: rtl/gcw_terms.sv
`timescale 1ns/1ps
module gcw_terms #(
  parameter  int GRAD_W = 11,
  parameter  int LINE_W = 256,
  parameter  int WIN    = 5,
  localparam int PROD_W = 2 * GRAD_W,
  localparam int TERM_W = PROD_W + 1,
  localparam int COL_W  = $clog2(LINE_W),
  localparam int ROW_W  = $clog2(WIN)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_sof,
  input  logic                     in_sol,
  input  logic signed [GRAD_W-1:0] live_gx,
  input  logic signed [GRAD_W-1:0] live_gy,
  input  logic signed [GRAD_W-1:0] bkg_gx,
  input  logic signed [GRAD_W-1:0] bkg_gy,
  output logic                     t_valid,
  output logic signed [TERM_W-1:0] t_mix,
  output logic signed [TERM_W-1:0] t_live,
  output logic signed [TERM_W-1:0] t_bkg,
  output logic        [COL_W-1:0]  t_col,
  output logic        [ROW_W-1:0]  t_row
);

  logic [COL_W-1:0] next_col_q;
  logic [ROW_W-1:0] cur_row_q;
  logic [COL_W-1:0] col_now;
  logic [ROW_W-1:0] row_now;

  // Position of the pixel on the inputs; rows saturate at WIN-1
  always_comb begin
    col_now = next_col_q;
    row_now = cur_row_q;
    if (in_sof) begin
      col_now = '0;
      row_now = '0;
    end else if (in_sol) begin
      col_now = '0;
      row_now = (cur_row_q == ROW_W'(WIN - 1)) ? cur_row_q : cur_row_q + 1'b1;
    end
  end

  logic signed [PROD_W-1:0] p_xx, p_yy, p_ll_x, p_ll_y, p_bb_x, p_bb_y;
  logic signed [TERM_W-1:0] mix_c, live_c, bkg_c;

  always_comb begin
    p_xx   = PROD_W'(live_gx) * PROD_W'(bkg_gx);
    p_yy   = PROD_W'(live_gy) * PROD_W'(bkg_gy);
    p_ll_x = PROD_W'(live_gx) * PROD_W'(live_gx);
    p_ll_y = PROD_W'(live_gy) * PROD_W'(live_gy);
    p_bb_x = PROD_W'(bkg_gx) * PROD_W'(bkg_gx);
    p_bb_y = PROD_W'(bkg_gy) * PROD_W'(bkg_gy);
    mix_c  = TERM_W'(p_xx) + TERM_W'(p_yy);
    live_c = TERM_W'(p_ll_x) + TERM_W'(p_ll_y);
    bkg_c  = TERM_W'(p_bb_x) + TERM_W'(p_bb_y);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_col_q <= '0;
      cur_row_q  <= '0;
      t_valid    <= 1'b0;
      t_mix      <= '0;
      t_live     <= '0;
      t_bkg      <= '0;
      t_col      <= '0;
      t_row      <= '0;
    end else begin
      t_valid <= in_valid;
      if (in_valid) begin
        next_col_q <= (col_now == COL_W'(LINE_W - 1)) ? col_now : col_now + 1'b1;
        cur_row_q  <= row_now;
        t_mix      <= mix_c;
        t_live     <= live_c;
        t_bkg      <= bkg_c;
        t_col      <= col_now;
        t_row      <= row_now;
      end
    end
  end

endmodule

// File: rtl/gcw_window.sv
`timescale 1ns/1ps
module gcw_window
  import gcw_pkg::*;
#(
  parameter  int TERM_W = 23,
  parameter  int LINE_W = 256,
  parameter  int WIN    = 5,
  localparam int COL_W  = $clog2(LINE_W),
  localparam int ROW_W  = $clog2(WIN),
  localparam int TAPS   = WIN * WIN,
  localparam int WORD_W = NUM_CH * TERM_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            t_valid,
  input  logic signed [TERM_W-1:0]        t_mix,
  input  logic signed [TERM_W-1:0]        t_live,
  input  logic signed [TERM_W-1:0]        t_bkg,
  input  logic        [COL_W-1:0]         t_col,
  input  logic        [ROW_W-1:0]         t_row,
  output logic [NUM_CH*TAPS*TERM_W-1:0]   taps_flat
);

  localparam int LB_N = WIN - 1;

  logic [WORD_W-1:0] line_mem [LB_N][LINE_W];
  logic [WORD_W-1:0] col_in   [WIN];
  logic [WORD_W-1:0] win_q    [WIN][WIN];
  logic [COL_W-1:0]  win_col_q;
  logic [ROW_W-1:0]  win_row_q;

  // Newest column: the current line, then one line per store going up
  always_comb begin
    col_in[0] = {t_bkg, t_live, t_mix};
    for (int k = 1; k < WIN; k++) col_in[k] = line_mem[k-1][t_col];
  end

  always_ff @(posedge clk) begin
    if (t_valid) begin
      for (int k = 0; k < LB_N; k++) line_mem[k][t_col] <= col_in[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < WIN; r++)
        for (int c = 0; c < WIN; c++) win_q[r][c] <= '0;
      win_col_q <= '0;
      win_row_q <= '0;
    end else if (t_valid) begin
      for (int r = 0; r < WIN; r++) begin
        win_q[r][0] <= col_in[r];
        for (int c = 1; c < WIN; c++) win_q[r][c] <= win_q[r][c-1];
      end
      win_col_q <= t_col;
      win_row_q <= t_row;
    end
  end

  // Positions above line 0 or left of column 0 count as zero
  always_comb begin
    taps_flat = '0;
    for (int ch = 0; ch < NUM_CH; ch++)
      for (int r = 0; r < WIN; r++)
        for (int c = 0; c < WIN; c++)
          if ((r <= int'(win_row_q)) && (c <= int'(win_col_q)))
            taps_flat[((ch * TAPS) + r * WIN + c) * TERM_W +: TERM_W] =
              win_q[r][c][ch * TERM_W +: TERM_W];
  end

endmodule

// File: rtl/gcw_adder_tree.sv
`timescale 1ns/1ps
module gcw_adder_tree
  import gcw_pkg::*;
#(
  parameter  int IN_N  = 25,
  parameter  int IN_W  = 23,
  parameter  int OUT_W = 28,
  localparam int DEPTH = tree_levels(IN_N)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [IN_N*IN_W-1:0]    din_flat,
  output logic signed [OUT_W-1:0] dout
);

  for (genvar l = 0; l <= DEPTH; l++) begin : g_lvl
    localparam int N = level_width(IN_N, l);
    for (genvar i = 0; i < N; i++) begin : g_n
      logic signed [OUT_W-1:0] q;
      if (l == 0) begin : g_leaf
        assign q = OUT_W'($signed(din_flat[i*IN_W +: IN_W]));
      end else if (2 * i + 1 < level_width(IN_N, l - 1)) begin : g_pair
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) q <= '0;
          else        q <= g_lvl[l-1].g_n[2*i].q + g_lvl[l-1].g_n[2*i+1].q;
        end
      end else begin : g_pass
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) q <= '0;
          else        q <= g_lvl[l-1].g_n[2*i].q;
        end
      end
    end
  end

  assign dout = g_lvl[DEPTH].g_n[0].q;

endmodule

// File: rtl/grad_corr_window_sum.sv
`timescale 1ns/1ps
module grad_corr_window_sum
  import gcw_pkg::*;
#(
  parameter  int GRAD_W = 11,
  parameter  int LINE_W = 256,
  parameter  int WIN    = 5,
  localparam int TERM_W = 2 * GRAD_W + 1,
  localparam int TAPS   = WIN * WIN,
  localparam int SUM_W  = TERM_W + $clog2(TAPS),
  localparam int COL_W  = $clog2(LINE_W),
  localparam int ROW_W  = $clog2(WIN),
  localparam int LAT    = 2 + tree_levels(TAPS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_sof,
  input  logic                     in_sol,
  input  logic signed [GRAD_W-1:0] live_gx,
  input  logic signed [GRAD_W-1:0] live_gy,
  input  logic signed [GRAD_W-1:0] bkg_gx,
  input  logic signed [GRAD_W-1:0] bkg_gy,
  output logic                     out_valid,
  output logic                     out_sof,
  output logic                     out_sol,
  output logic signed [SUM_W-1:0]  out_mix,
  output logic signed [SUM_W-1:0]  out_live_e,
  output logic signed [SUM_W-1:0]  out_bkg_e
);

  logic                     t_valid;
  logic signed [TERM_W-1:0] t_mix, t_live, t_bkg;
  logic [COL_W-1:0]         t_col;
  logic [ROW_W-1:0]         t_row;
  logic [NUM_CH*TAPS*TERM_W-1:0] taps_flat;
  logic signed [SUM_W-1:0]  sums [NUM_CH];

  gcw_terms #(.GRAD_W(GRAD_W), .LINE_W(LINE_W), .WIN(WIN)) u_terms (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_sof(in_sof), .in_sol(in_sol),
    .live_gx(live_gx), .live_gy(live_gy), .bkg_gx(bkg_gx), .bkg_gy(bkg_gy),
    .t_valid(t_valid), .t_mix(t_mix), .t_live(t_live), .t_bkg(t_bkg),
    .t_col(t_col), .t_row(t_row)
  );

  gcw_window #(.TERM_W(TERM_W), .LINE_W(LINE_W), .WIN(WIN)) u_window (
    .clk(clk), .rst_n(rst_n),
    .t_valid(t_valid), .t_mix(t_mix), .t_live(t_live), .t_bkg(t_bkg),
    .t_col(t_col), .t_row(t_row), .taps_flat(taps_flat)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    gcw_adder_tree #(.IN_N(TAPS), .IN_W(TERM_W), .OUT_W(SUM_W)) u_tree (
      .clk(clk), .rst_n(rst_n),
      .din_flat(taps_flat[ch*TAPS*TERM_W +: TAPS*TERM_W]),
      .dout(sums[ch])
    );
  end

  assign out_mix    = sums[CH_MIX];
  assign out_live_e = sums[CH_LIVE_E];
  assign out_bkg_e  = sums[CH_BKG_E];

  // Sideband travels alongside the data for exactly LAT cycles
  logic [2:0] side_q [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) side_q[i] <= '0;
    end else begin
      side_q[0] <= {in_valid, in_valid & in_sof, in_valid & (in_sol | in_sof)};
      for (int i = 1; i < LAT; i++) side_q[i] <= side_q[i-1];
    end
  end

  assign out_valid = side_q[LAT-1][2];
  assign out_sof   = side_q[LAT-1][1];
  assign out_sol   = side_q[LAT-1][0];

endmodule

// File: rtl/grad_corr_window_sum_chk.sv
`timescale 1ns/1ps
module grad_corr_window_sum_chk #(
  parameter int GRAD_W = 11,
  parameter int WIN    = 5,
  parameter int SUM_W  = 28,
  parameter int LAT    = 7
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     in_sof,
  input logic                     in_sol,
  input logic signed [GRAD_W-1:0] live_gx,
  input logic signed [GRAD_W-1:0] live_gy,
  input logic signed [GRAD_W-1:0] bkg_gx,
  input logic signed [GRAD_W-1:0] bkg_gy,
  input logic                     out_valid,
  input logic                     out_sof,
  input logic                     out_sol,
  input logic signed [SUM_W-1:0]  out_mix,
  input logic signed [SUM_W-1:0]  out_live_e,
  input logic signed [SUM_W-1:0]  out_bkg_e
);

  localparam longint ENERGY_MAX = longint'(WIN * WIN) * (longint'(1) << (2 * GRAD_W - 1));

  int unsigned since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  since_rst <= 0;
    else if (since_rst < LAT)    since_rst <= since_rst + 1;
  end

  logic signed [SUM_W-1:0] own_live;
  assign own_live = SUM_W'(live_gx) * SUM_W'(live_gx) + SUM_W'(live_gy) * SUM_W'(live_gy);

  AST_ENERGY_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_live_e >= 0 && out_bkg_e >= 0)); // R1

  AST_MIX_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (longint'(out_mix) * longint'(out_mix) <=
                   longint'(out_live_e) * longint'(out_bkg_e))); // R1

  AST_FIRST_PIXEL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= LAT && out_valid && out_sof) |-> out_live_e == $past(own_live, LAT)); // R3

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= LAT) |-> out_valid == $past(in_valid, LAT)); // R4

  AST_SOF_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= LAT) |-> out_sof == $past(in_valid && in_sof, LAT)); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (longint'(out_live_e) <= ENERGY_MAX && longint'(out_bkg_e) <= ENERGY_MAX)); // R7

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < LAT) |-> !out_valid); // R8

  AST_FLAGS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_sof && !out_sol)); // R9

endmodule

bind grad_corr_window_sum grad_corr_window_sum_chk #(
  .GRAD_W(GRAD_W), .WIN(WIN), .SUM_W(SUM_W), .LAT(LAT)
) u_chk (.*);

// File: tb/grad_corr_window_sum_test.sv
`timescale 1ns/1ps
module grad_corr_window_sum_test;

  localparam int GW  = 11;
  localparam int LW  = 8;
  localparam int WN  = 5;
  localparam int H   = 6;
  localparam int W   = 8;
  localparam int SW  = 28;
  localparam int LAT = 7;   // term stage + window stage + five tree levels

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic in_valid = 1'b0, in_sof = 1'b0, in_sol = 1'b0;
  logic signed [GW-1:0] live_gx = '0, live_gy = '0, bkg_gx = '0, bkg_gy = '0;
  logic out_valid, out_sof, out_sol;
  logic signed [SW-1:0] out_mix, out_live_e, out_bkg_e;

  grad_corr_window_sum #(.GRAD_W(GW), .LINE_W(LW), .WIN(WN)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_sof(in_sof), .in_sol(in_sol),
    .live_gx(live_gx), .live_gy(live_gy), .bkg_gx(bkg_gx), .bkg_gy(bkg_gy),
    .out_valid(out_valid), .out_sof(out_sof), .out_sol(out_sol),
    .out_mix(out_mix), .out_live_e(out_live_e), .out_bkg_e(out_bkg_e)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int gfx [H][W];
  int gfy [H][W];
  int gbx [H][W];
  int gby [H][W];

  int    q_mix[$], q_live[$], q_bkg[$], q_t[$];
  bit    q_sof[$], q_sol[$];
  string q_req[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int wsum(input int ch, input int r, input int c);
    int s;
    s = 0;
    for (int rr = r - WN + 1; rr <= r; rr++)
      for (int cc = c - WN + 1; cc <= c; cc++)
        if (rr >= 0 && cc >= 0) begin
          case (ch)
            0:       s += gfx[rr][cc] * gbx[rr][cc] + gfy[rr][cc] * gby[rr][cc];
            1:       s += gfx[rr][cc] * gfx[rr][cc] + gfy[rr][cc] * gfy[rr][cc];
            default: s += gbx[rr][cc] * gbx[rr][cc] + gby[rr][cc] * gby[rr][cc];
          endcase
        end
    return s;
  endfunction

  function automatic int rnd_grad();
    return int'($urandom_range(2047)) - 1024;
  endfunction

  // 0 random, 1 lone pixel, 2 all ones, 3 all minimum, 4 opposing extremes
  task automatic fill(input int mode);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        case (mode)
          0: begin gfx[r][c] = rnd_grad(); gfy[r][c] = rnd_grad();
                   gbx[r][c] = rnd_grad(); gby[r][c] = rnd_grad(); end
          1: begin gfx[r][c] = 0; gfy[r][c] = 0; gbx[r][c] = 0; gby[r][c] = 0; end
          2: begin gfx[r][c] = 1; gfy[r][c] = 1; gbx[r][c] = 1; gby[r][c] = 1; end
          3: begin gfx[r][c] = -1024; gfy[r][c] = -1024; gbx[r][c] = -1024; gby[r][c] = -1024; end
          default: begin gfx[r][c] = -1024; gfy[r][c] = -1024; gbx[r][c] = 1023; gby[r][c] = 1023; end
        endcase
      end
    if (mode == 1) begin
      gfx[2][3] = 300; gfy[2][3] = -200; gbx[2][3] = -150; gby[2][3] = 400;
    end
  endtask

  task automatic idle_cycle();
    @(posedge clk); #1;
    in_valid = 1'b0;
    in_sof   = 1'($urandom_range(1));
    in_sol   = 1'($urandom_range(1));
    live_gx  = GW'(rnd_grad()); live_gy = GW'(rnd_grad());
    bkg_gx   = GW'(rnd_grad()); bkg_gy  = GW'(rnd_grad());
  endtask

  task automatic send_frame(input string req, input bit gaps, input int lead_idle);
    for (int i = 0; i < lead_idle; i++) idle_cycle();
    for (int r = 0; r < H; r++) begin
      if (gaps) for (int i = 0; i < 3; i++) idle_cycle();
      for (int c = 0; c < W; c++) begin
        if (gaps) begin
          int n;
          n = int'($urandom_range(2));
          for (int i = 0; i < n; i++) idle_cycle();
        end
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_sof   = (r == 0 && c == 0);
        in_sol   = (c == 0);
        live_gx  = GW'(gfx[r][c]); live_gy = GW'(gfy[r][c]);
        bkg_gx   = GW'(gbx[r][c]); bkg_gy  = GW'(gby[r][c]);
        q_mix.push_back(wsum(0, r, c));
        q_live.push_back(wsum(1, r, c));
        q_bkg.push_back(wsum(2, r, c));
        q_sof.push_back(r == 0 && c == 0);
        q_sol.push_back(c == 0);
        q_t.push_back(cyc);
        q_req.push_back(req);
      end
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_sof = 1'b0; in_sol = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (q_mix.size() == 0) begin
          check(1'b0, "R2", "result with no pixel pending", 1, 0);
        end else begin
          int e_mix, e_live, e_bkg, e_t;
          bit e_sof, e_sol;
          string rq;
          e_mix = q_mix.pop_front(); e_live = q_live.pop_front(); e_bkg = q_bkg.pop_front();
          e_sof = q_sof.pop_front(); e_sol = q_sol.pop_front(); e_t = q_t.pop_front();
          rq = q_req.pop_front();
          check(out_mix == SW'(e_mix), rq, "mix sum", longint'(out_mix), e_mix);
          check(out_live_e == SW'(e_live), rq, "live energy sum", longint'(out_live_e), e_live);
          check(out_bkg_e == SW'(e_bkg), rq, "background energy sum", longint'(out_bkg_e), e_bkg);
          check(cyc - e_t == LAT, "R4", "latency", cyc - e_t, LAT);
          check(out_sof == e_sof && out_sol == e_sol, "R4", "flags sof/sol",
                {out_sof, out_sol}, {e_sof, e_sol});
        end
      end else begin
        check(!out_sof && !out_sol, "R9", "flags while not valid", {out_sof, out_sol}, 0);
      end
    end
  end

  initial begin
    void'($urandom(32'd11));
    fork
      begin
        repeat (3) @(negedge clk);
        check(!out_valid && !out_sof && !out_sol, "R8", "outputs during reset",
              {out_valid, out_sof, out_sol}, 0);
        @(posedge clk); #1; rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(!out_valid, "R8", "valid after reset", out_valid, 0);

        fill(1); send_frame("R1", 1'b0, 2);
        fill(2); send_frame("R3", 1'b0, 4);
        fill(0); send_frame("R2", 1'b0, 4);
        fill(0); send_frame("R2", 1'b0, 0);
        fill(0); send_frame("R5", 1'b1, 4);
        fill(3); send_frame("R7", 1'b0, 4);
        fill(0); send_frame("R6", 1'b0, 0);
        fill(4); send_frame("R7", 1'b0, 1);
        fill(2); send_frame("R6", 1'b1, 0);
        repeat (LAT + 6) @(posedge clk);
        @(negedge clk);
        check(q_mix.size() == 0, "R2", "results still missing", q_mix.size(), 0);
      end
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog expired, pending %0d expected 0", q_mix.size());
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule